// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector with Debounce Filter

This block watches the sixteen input bits of a general-purpose I/O port and latches a status bit for every pin that meets its programmed trigger condition. Each pin can fire on a rising edge, a falling edge, both edges, a high level or a low level. Inputs arrive already synchronized to the system clock. The pad interface and the interrupt controller lie outside this block.

An optional debounce stage can be enabled pin by pin. It samples the inputs on a shared sample tick. That tick is produced by dividing a base rate by 2^N, with N running from 0 to 15. The base rate is either every system clock or a slow reference supplied as a single-cycle enable pulse. The filtered level changes only when two consecutive samples agree.

Status bits stay set until software writes a 1 to their clear input. The OR of all status bits drives the interrupt request. When the always-on detection option is off, a pin's edge detector holds its history while the pin has no trigger enabled.

Top module: `gpio_irq_detect`

## Requirements
- R1: With debounce off and edge mode selected (level_mode_i bit = 0), a 0-to-1 change on a pin with rise_en_i set sets its status bit on the first clock edge that samples the new level. A 1-to-0 change with only rise_en_i set does not set it.
- R2: In edge mode, fall_en_i alone catches 1-to-0 changes only. Setting rise_en_i and fall_en_i together catches both directions.
- R3: In level mode (level_mode_i bit = 1), the status bit is set on every clock while the pin is high (with rise_en_i) or low (with fall_en_i). A clear has no effect while that level persists and takes effect once the level is gone.
- R4: The sample tick occurs once every 2^N base events, where N = db_sel_i. The base event is every clock when db_src_i = 0 and each slow_tick_i pulse when db_src_i = 1. Without base events no sample is taken. After reset the divider starts from zero.
- R5: On a pin with db_en_i set, the filtered level takes a new value only on a sample tick whose sample equals the previous sample. A pulse shorter than one sample period is rejected.
- R6: A pin with db_en_i clear is not filtered, and its events are detected with no added delay.
- R7: With detect_always_i = 1, every pin's edge history follows its filtered input. With detect_always_i = 0, a pin with neither enable set keeps its old history, so an edge that occurs while the pin is disabled is reported on the first clock after an enable is set.
- R8: A 1 in clr_i clears the matching status bit on the next clock edge and leaves all other bits unchanged. Status bits that are not cleared stay set.
- R9: When a clear and a new event for the same pin fall in the same clock, the status bit stays set.
- R10: irq_o is high exactly when at least one status bit is set.
- R11: After reset all status bits and irq_o are 0.
- R12: A pin with neither rise_en_i nor fall_en_i set never sets its status bit, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 16 | Synchronized pin levels |
| rise_en_i | input | 16 | Per-pin rising-edge / high-level enable |
| fall_en_i | input | 16 | Per-pin falling-edge / low-level enable |
| level_mode_i | input | 16 | Per-pin trigger kind: 1 level, 0 edge |
| db_en_i | input | 16 | Per-pin debounce enable |
| db_sel_i | input | 4 | Sample period exponent N (2^N base events) |
| db_src_i | input | 1 | Divider base: 0 system clock, 1 slow_tick_i |
| slow_tick_i | input | 1 | Slow reference enable pulse, one clock wide |
| detect_always_i | input | 1 | Keep edge history running on all pins |
| clr_i | input | 16 | Write-1-to-clear pulse for status bits |
| status_o | output | 16 | Latched per-pin event status |
| irq_o | output | 1 | OR of all status bits |

## Verification
The assertions take pin_i to be synchronous to clk_i and slow_tick_i to be a clean single-clock pulse. They also take clr_i to be a one-clock strobe. The debounce properties further assume that db_sel_i does not change in the cycle it is checked. The stimulus changes every input only just after a falling clock edge. It changes configuration only while the affected pins are quiet, and it applies a reset before the slow-source test so that the divider phase is known. The glitch test holds pulses to fewer cycles than one sample period.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_kind_e;

  // divider counter width for a given selector width
  function automatic int unsigned div_cnt_w(int unsigned sel_w);
    return (1 << sel_w) - 1;
  endfunction

endpackage

// File: rtl/gpio_db_tick.sv
module gpio_db_tick
  import gpio_irq_pkg::*;
#(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_i,
  input  logic             slow_tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  localparam int unsigned CNT_W = div_cnt_w(SEL_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             base;
  logic             wrap;

  // limit = 2^sel - 1 as a thermometer mask
  always_comb begin
    for (int j = 0; j < CNT_W; j++) begin
      limit[j] = (sel_i > SEL_W'(j));
    end
  end

  assign base = src_i ? slow_tick_i : 1'b1;
  assign wrap = (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (base) begin
      cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign tick_o = base && wrap;

  AST_TICK_NEEDS_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_i && !slow_tick_i |-> !tick_o); // R4
  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tick_o) && !src_i && $past(sel_i) != '0 && $stable(sel_i) && $stable(src_i)
    |-> !tick_o); // R4

endmodule

// File: rtl/gpio_db_filter.sv
module gpio_db_filter #(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] db_en_i,
  output logic [NUM_PINS-1:0] filt_o
);

  logic [NUM_PINS-1:0] smp_q;
  logic [NUM_PINS-1:0] flt_q;
  logic [NUM_PINS-1:0] agree;

  assign agree = ~(pin_i ^ smp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= '0;
      flt_q <= '0;
    end else if (tick_i) begin
      smp_q <= pin_i;
      flt_q <= (agree & pin_i) | (~agree & flt_q);
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_sel
    assign filt_o[i] = db_en_i[i] ? flt_q[i] : pin_i[i];
  end

  AST_FILT_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(flt_q)); // R5
  AST_FILT_TWO_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flt_q ^ $past(flt_q)) & ($past(smp_q) ^ $past(pin_i))) == '0); // R5

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] filt_i,
  input  logic [NUM_PINS-1:0] rise_en_i,
  input  logic [NUM_PINS-1:0] fall_en_i,
  input  logic [NUM_PINS-1:0] level_i,
  input  logic                always_i,
  output logic [NUM_PINS-1:0] evt_o
);

  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] active;

  assign active = always_i ? '1 : (rise_en_i | fall_en_i);

  // history frozen while a pin's detector is idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= (active & filt_i) | (~active & prev_q);
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic hit_lvl, hit_edge;
    assign hit_lvl  = (rise_en_i[i] & filt_i[i]) | (fall_en_i[i] & ~filt_i[i]);
    assign hit_edge = (rise_en_i[i] & filt_i[i] & ~prev_q[i])
                    | (fall_en_i[i] & ~filt_i[i] & prev_q[i]);
    assign evt_o[i] = (trig_kind_e'(level_i[i]) == TRIG_LEVEL) ? hit_lvl : hit_edge;
  end

  AST_HIST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~$past(active) & ($past(prev_q) ^ prev_q)) == '0); // R7
  AST_HIST_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(always_i) |-> prev_q == $past(filt_i)); // R7

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned SEL_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] rise_en_i,
  input  logic [NUM_PINS-1:0] fall_en_i,
  input  logic [NUM_PINS-1:0] level_mode_i,
  input  logic [NUM_PINS-1:0] db_en_i,
  input  logic [SEL_W-1:0]    db_sel_i,
  input  logic                db_src_i,
  input  logic                slow_tick_i,
  input  logic                detect_always_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] status_o,
  output logic                irq_o
);

  logic                sample_tick;
  logic [NUM_PINS-1:0] filt;
  logic [NUM_PINS-1:0] evt;
  logic [NUM_PINS-1:0] status_q;

  gpio_db_tick #(.SEL_W(SEL_W)) i_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (db_src_i),
    .slow_tick_i (slow_tick_i),
    .sel_i       (db_sel_i),
    .tick_o      (sample_tick)
  );

  gpio_db_filter #(.NUM_PINS(NUM_PINS)) i_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (sample_tick),
    .pin_i   (pin_i),
    .db_en_i (db_en_i),
    .filt_o  (filt)
  );

  gpio_evt_detect #(.NUM_PINS(NUM_PINS)) i_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .filt_i    (filt),
    .rise_en_i (rise_en_i),
    .fall_en_i (fall_en_i),
    .level_i   (level_mode_i),
    .always_i  (detect_always_i),
    .evt_o     (evt)
  );

  // new event beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | evt;
  end

  assign status_o = status_q;
  assign irq_o    = |status_q;

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(status_q) & ~$past(clr_i) & ~status_q) == '0); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_i) & ~$past(evt) & status_q) == '0); // R8
  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(evt) & ~status_q) == '0); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & ~$past(status_q) & ~($past(rise_en_i) | $past(fall_en_i))) == '0); // R12

endmodule

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;

  localparam int N = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] pin_i = '0;
  logic [N-1:0] rise_en_i = '0;
  logic [N-1:0] fall_en_i = '0;
  logic [N-1:0] level_mode_i = '0;
  logic [N-1:0] db_en_i = '0;
  logic [3:0]   db_sel_i = '0;
  logic         db_src_i = 1'b0;
  logic         slow_tick_i = 1'b0;
  logic         detect_always_i = 1'b0;
  logic [N-1:0] clr_i = '0;
  logic [N-1:0] status_o;
  logic         irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  gpio_irq_detect i_gpio_irq_detect (
    .clk_i, .rst_ni, .pin_i, .rise_en_i, .fall_en_i, .level_mode_i,
    .db_en_i, .db_sel_i, .db_src_i, .slow_tick_i, .detect_always_i,
    .clr_i, .status_o, .irq_o
  );

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk_vec(string req, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s status act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_irq(string req, logic exp);
    total++;
    if (irq_o !== exp) begin
      bad++;
      $display("FAIL %s irq act=%b exp=%b", req, irq_o, exp);
    end
  endtask

  task automatic clear(logic [N-1:0] m);
    clr_i = m;
    step(1);
    clr_i = '0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    step(2);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    chk_vec("R11", status_o, '0);
    chk_irq("R11", 1'b0);
  endtask

  task automatic t_rise();
    rise_en_i[0] = 1'b1;
    pin_i[0] = 1'b1;
    step(1);
    chk_vec("R1", status_o, 16'h0001);
    chk_irq("R10", 1'b1);
    clear(16'h0001);
    chk_vec("R8", status_o, '0);
    chk_irq("R10", 1'b0);
    pin_i[0] = 1'b0;
    step(2);
    chk_vec("R1 fall ignored", status_o, '0);
    rise_en_i[0] = 1'b0;
  endtask

  task automatic t_fall_both();
    fall_en_i[1] = 1'b1;
    pin_i[1] = 1'b1;
    step(1);
    chk_vec("R2 rise ignored", status_o, '0);
    pin_i[1] = 1'b0;
    step(1);
    chk_vec("R2 fall", status_o, 16'h0002);
    clear(16'h0002);
    rise_en_i[1] = 1'b1;
    pin_i[1] = 1'b1;
    step(1);
    chk_vec("R2 both rise", status_o, 16'h0002);
    clear(16'h0002);
    pin_i[1] = 1'b0;
    step(1);
    chk_vec("R2 both fall", status_o, 16'h0002);
    clear(16'h0002);
    rise_en_i[1] = 1'b0;
    fall_en_i[1] = 1'b0;
  endtask

  task automatic t_level();
    level_mode_i[2] = 1'b1;
    rise_en_i[2] = 1'b1;
    pin_i[2] = 1'b1;
    step(1);
    chk_vec("R3 high", status_o, 16'h0004);
    clear(16'h0004);
    chk_vec("R3 clear blocked", status_o, 16'h0004);
    pin_i[2] = 1'b0;
    step(1);
    clear(16'h0004);
    chk_vec("R3 clear after", status_o, '0);
    step(2);
    chk_vec("R3 stays clear", status_o, '0);
    rise_en_i[2] = 1'b0;
    level_mode_i[3] = 1'b1;
    fall_en_i[3] = 1'b1;
    step(1);
    chk_vec("R3 low", status_o, 16'h0008);
    fall_en_i[3] = 1'b0;
    clear(16'h0008);
    chk_vec("R3 low cleared", status_o, '0);
    level_mode_i[3:2] = 2'b00;
  endtask

  task automatic t_clr_event();
    rise_en_i[4] = 1'b1;
    pin_i[4] = 1'b1;
    step(1);
    pin_i[4] = 1'b0;
    step(1);
    pin_i[4] = 1'b1;
    clr_i = 16'h0010;
    step(1);
    clr_i = '0;
    chk_vec("R9", status_o, 16'h0010);
    clear(16'h0010);
    chk_vec("R9 cleared", status_o, '0);
    pin_i[4] = 1'b0;
    rise_en_i[4] = 1'b0;
    step(1);
  endtask

  task automatic t_w1c();
    rise_en_i[6:5] = 2'b11;
    pin_i[6:5] = 2'b11;
    step(1);
    chk_vec("R8 set", status_o, 16'h0060);
    clear(16'h0020);
    chk_vec("R8 partial", status_o, 16'h0040);
    step(3);
    chk_vec("R8 sticky", status_o, 16'h0040);
    clear(16'h0040);
    chk_vec("R8 all", status_o, '0);
    rise_en_i[6:5] = 2'b00;
    pin_i[6:5] = 2'b00;
    step(1);
  endtask

  task automatic t_debounce();
    db_sel_i = 4'd0;
    db_src_i = 1'b0;
    db_en_i[7] = 1'b1;
    rise_en_i[8:7] = 2'b11;
    pin_i[8:7] = 2'b11;
    step(1);
    chk_vec("R6 unfiltered", status_o, 16'h0100);
    step(1);
    chk_vec("R5 one sample", status_o, 16'h0100);
    step(1);
    chk_vec("R5 two samples", status_o, 16'h0180);
    clear(16'h0180);
    pin_i[8:7] = 2'b00;
    db_sel_i = 4'd2;
    step(12);
    pin_i[7] = 1'b1;
    step(2);
    pin_i[7] = 1'b0;
    step(12);
    chk_vec("R5 glitch", status_o, '0);
    pin_i[7] = 1'b1;
    step(12);
    chk_vec("R5 held", status_o, 16'h0080);
    clear(16'h0080);
    pin_i[7] = 1'b0;
    step(12);
    rise_en_i[8:7] = 2'b00;
    db_en_i[7] = 1'b0;
    db_sel_i = 4'd0;
  endtask

  task automatic pulse();
    slow_tick_i = 1'b1;
    step(1);
    slow_tick_i = 1'b0;
  endtask

  task automatic t_source();
    db_src_i = 1'b1;
    db_sel_i = 4'd1;
    db_en_i[12] = 1'b1;
    rise_en_i[12] = 1'b1;
    do_reset();
    pin_i[12] = 1'b1;
    step(6);
    chk_vec("R4 no base", status_o, '0);
    for (int k = 0; k < 3; k++) begin
      pulse();
      step(3);
    end
    chk_vec("R4 three pulses", status_o, '0);
    pulse();
    chk_vec("R4 filter edge", status_o, '0);
    step(1);
    chk_vec("R4 fourth pulse", status_o, 16'h1000);
    clear(16'h1000);
    rise_en_i[12] = 1'b0;
    db_en_i[12] = 1'b0;
    pin_i[12] = 1'b0;
    db_src_i = 1'b0;
    db_sel_i = 4'd0;
    step(2);
    chk_vec("R4 clean", status_o, '0);
  endtask

  task automatic t_always();
    detect_always_i = 1'b0;
    pin_i[9] = 1'b1;
    pin_i[11] = 1'b1;
    step(3);
    chk_vec("R12 disabled", status_o, '0);
    rise_en_i[9] = 1'b1;
    step(1);
    chk_vec("R7 stale edge", status_o, 16'h0200);
    clear(16'h0200);
    pin_i[11] = 1'b0;
    detect_always_i = 1'b1;
    pin_i[10] = 1'b1;
    step(3);
    rise_en_i[10] = 1'b1;
    step(2);
    chk_vec("R7 always on", status_o, '0);
    pin_i[11] = 1'b1;
    step(2);
    chk_vec("R12 always on", status_o, '0);
    rise_en_i[10:9] = 2'b00;
    pin_i = '0;
    detect_always_i = 1'b0;
    step(1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_rise();
    t_fall_both();
    t_level();
    t_clr_event();
    t_w1c();
    t_debounce();
    t_always();
    t_source();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule